// File: doc/BRIEF.md
# Sequential Integer Multiply-Divide Unit

This block is an iterative 32-bit integer engine. It forms either a full 64-bit product or a quotient with its remainder, and it can treat the operands as signed or as unsigned numbers. A request is one cycle of `start` carrying the two operands, an operation select and a signedness flag. The unit then stays `busy` for a fixed number of cycles and pulses `done` when both result registers, `hi` and `lo`, hold the new answer. The results stay there until the next operation completes. A product wider than 32 bits is detected by looking at `hi`.

A single 64-bit working register and one 33-bit adder/subtractor carry both algorithms. For a multiply the register starts with the multiplier in its low half. Each step conditionally adds the multiplicand into the upper half and shifts everything one place right. For a divide the register starts with the dividend in its low half. Each step makes a trial subtraction of the divisor from the shifted upper half. The difference is kept and a 1 enters at the bottom only when the difference is not negative; otherwise the old partial remainder is kept and a 0 enters. In signed mode the operands are first reduced to magnitudes, and a final cycle restores the signs. The unit makes no special case for a zero divisor or for quotient overflow.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset `busy`, `done`, `hi` and `lo` are all 0.
- R2: With `op_div`=0 and `is_signed`=0, {`hi`,`lo`} becomes the unsigned 64-bit product of `opa` and `opb`, with `hi` as the upper 32 bits.
- R3: With `op_div`=0 and `is_signed`=1, {`hi`,`lo`} becomes the two's-complement 64-bit product of the signed operands.
- R4: With `op_div`=1 and `is_signed`=0 and a nonzero `opb`, `lo` becomes `opa`/`opb` and `hi` becomes `opa` mod `opb`.
- R5: With `op_div`=1 and `is_signed`=1 and a nonzero `opb`, the quotient in `lo` is rounded toward zero and is negative only when the operand signs differ. The remainder in `hi` carries the sign of the dividend.
- R6: A zero divisor gives `hi` = `opa`. Unsigned, `lo` = 0xFFFFFFFF. Signed, `lo` = 0xFFFFFFFF for a non-negative dividend and 0x00000001 for a negative one.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives `lo` = 0x80000000 and `hi` = 0.
- R8: A start seen while idle raises `busy` on the next cycle. `busy` stays high for exactly 34 cycles (one setup, 32 steps, one fix-up). `done` is high for one cycle, the first cycle with `busy` low, and `hi`/`lo` change on that same edge.
- R9: A `start` while `busy` is high is ignored: the running operation finishes on time with its own result.
- R10: `hi` and `lo` change only in a cycle where `done` is high and otherwise hold their value.
- R11: Operation encoding: `op_div`=0 selects multiply and `op_div`=1 selects divide. `is_signed`=1 selects two's-complement operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an operation (taken only when not busy) |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| is_signed | input | 1 | 1 = operands are two's complement |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are written |
| hi | output | 32 | Upper product half or remainder |
| lo | output | 32 | Lower product half or quotient |

## Verification
The hardest situations to reach from the ports are a second `start` that arrives mid-operation and a new `start` that lands in the very cycle `done` is high. Arriving mid-operation must have no effect; landing on `done` must be accepted. The stimulus gets there by counting cycles from an accepted request: it pulses `start` with different operands a few cycles into an operation, and in another case it waits for `done` and raises `start` at once. The sign fix-up corners are reached only through directed operands: mixed-sign division, a zero divisor with each dividend sign, and the most negative dividend divided by minus one. Random operands with small divisors fill in the rest.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ITER,
    PH_FIX
  } phase_t;

  // two's-complement negate when requested
  function automatic logic [63:0] cond_neg64(input logic [63:0] v, input logic neg);
    return neg ? (~v + 64'd1) : v;
  endfunction

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase,
  output logic   accept,
  output logic   busy,
  output logic   done
);
  localparam int CW = $clog2(STEPS + 1);

  logic [CW-1:0] step_cnt;

  assign accept = (phase == PH_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      step_cnt <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_SETUP;
            busy  <= 1'b1;
          end
        end
        PH_SETUP: begin
          phase    <= PH_ITER;
          step_cnt <= '0;
        end
        PH_ITER: begin
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == CW'(STEPS - 1)) phase <= PH_FIX;
        end
        PH_FIX: begin
          phase <= PH_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/muldiv_alu.sv
module muldiv_alu #(
  parameter int W = 32
) (
  input  logic [W:0]   x,
  input  logic [W:0]   y,
  input  logic         sub,
  output logic [W+1:0] res
);
  // For a subtraction, res[W+1] = 1 means x - y did not borrow.
  always_comb begin
    res = {1'b0, x} + {1'b0, (y ^ {(W+1){sub}})} + (W+2)'(sub);
  end
endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  phase_t       phase,
  input  logic         accept,
  input  logic         op_div_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int DW = 2 * W;

  logic          is_div;
  logic          neg_main;
  logic          neg_rem;
  logic [W-1:0]  mag_a;
  logic [W-1:0]  mag_b;
  logic [DW-1:0] acc;

  logic [W:0]    alu_x;
  logic [W:0]    alu_y;
  logic [W+1:0]  alu_r;
  logic          sgn_a;
  logic          sgn_b;

  assign sgn_a = signed_i & a_i[W-1];
  assign sgn_b = signed_i & b_i[W-1];

  // one shared adder: add for multiply, trial subtract for divide
  assign alu_x = is_div ? acc[DW-1:W-1] : {1'b0, acc[DW-1:W]};
  assign alu_y = {1'b0, (is_div ? mag_b : mag_a)};

  muldiv_alu #(.W(W)) u_alu (
    .x   (alu_x),
    .y   (alu_y),
    .sub (is_div),
    .res (alu_r)
  );

  logic [DW-1:0] prod_fix;
  logic [W-1:0]  quo_fix;
  logic [W-1:0]  rem_fix;

  always_comb begin
    prod_fix = DW'(cond_neg64(64'(acc), neg_main));
    quo_fix  = neg_main ? (~acc[W-1:0] + 1'b1) : acc[W-1:0];
    rem_fix  = neg_rem ? (~acc[DW-1:W] + 1'b1) : acc[DW-1:W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      is_div   <= 1'b0;
      neg_main <= 1'b0;
      neg_rem  <= 1'b0;
      mag_a    <= '0;
      mag_b    <= '0;
      acc      <= '0;
      hi       <= '0;
      lo       <= '0;
    end else begin
      if (accept) begin
        is_div   <= op_div_i;
        neg_main <= sgn_a ^ sgn_b;
        neg_rem  <= sgn_a;
        mag_a    <= sgn_a ? (~a_i + 1'b1) : a_i;
        mag_b    <= sgn_b ? (~b_i + 1'b1) : b_i;
      end
      case (phase)
        PH_SETUP: acc <= {{W{1'b0}}, (is_div ? mag_a : mag_b)};
        PH_ITER: begin
          if (is_div) begin
            if (alu_r[W+1]) acc <= {alu_r[W-1:0], acc[W-2:0], 1'b1};
            else            acc <= {acc[DW-2:0], 1'b0};
          end else begin
            if (acc[0]) acc <= {alu_r[W:0], acc[W-1:1]};
            else        acc <= {1'b0, acc[DW-1:1]};
          end
        end
        PH_FIX: begin
          if (is_div) begin
            hi <= rem_fix;
            lo <= quo_fix;
          end else begin
            hi <= prod_fix[DW-1:W];
            lo <= prod_fix[W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_div,
  input  logic         is_signed,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  phase_t phase;
  logic   accept;

  muldiv_ctrl #(.STEPS(W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .phase  (phase),
    .accept (accept),
    .busy   (busy),
    .done   (done)
  );

  muldiv_core #(.W(W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .accept   (accept),
    .op_div_i (op_div),
    .signed_i (is_signed),
    .a_i      (opa),
    .b_i      (opb),
    .hi       (hi),
    .lo       (lo)
  );

endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int BUSY_LEN = W + 2;
  localparam int BCW      = $clog2(BUSY_LEN + 2);

  logic [BCW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R8 and R9: every operation lasts exactly the nominal length, so a restart is never taken
  a_r8_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == BCW'(BUSY_LEN)));

  // R8: request taken when idle
  a_r8_start_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R8: done is a single pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done follows the end of busy
  a_r8_done_end: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R10: results move only with done
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable({hi, lo}) |-> done);

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .hi    (hi),
  .lo    (lo)
);

// File: tb/muldiv_hilo_bench.sv
module muldiv_hilo_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_div = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        busy;
  logic        done;
  logic [31:0] hi;
  logic [31:0] lo;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit running = 0;
  string cur_tag = "R1";

  muldiv_hilo u_muldiv_hilo (
    .clk(clk), .rst(rst), .start(start), .op_div(op_div), .is_signed(is_signed),
    .opa(opa), .opb(opb), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  function automatic logic [63:0] ref_result(input logic dv, input logic sg,
                                             input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (!dv) begin
      if (sg) begin
        q = sa * sb;
        p = 64'(q);
      end else begin
        p = {32'd0, a} * {32'd0, b};
      end
      return p;
    end
    if (b == 32'd0) begin
      if (sg && a[31]) return {a, 32'd1};
      return {a, 32'hFFFF_FFFF};
    end
    if (sg) begin
      q = sa / sb;
      r = sa % sb;
      return {r[31:0], q[31:0]};
    end
    return {a % b, a / b};
  endfunction

  logic        m_busy = 0;
  logic        m_done = 0;
  logic [31:0] m_hi = 0;
  logic [31:0] m_lo = 0;
  logic [63:0] m_pend = 0;
  int          m_cnt = 0;
  string       m_tag = "R1";
  string       m_pend_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_hi = 0; m_lo = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          m_done = 1;
          m_hi = m_pend[63:32];
          m_lo = m_pend[31:0];
          m_tag = m_pend_tag;
        end
      end else if (start) begin
        m_pend = ref_result(op_div, is_signed, opa, opb);
        m_pend_tag = cur_tag;
        m_busy = 1;
        m_cnt = 34;
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (running && !rst) begin
      check(busy === m_busy, "R8 busy", 64'(busy), 64'(m_busy));
      check(done === m_done, "R8 done", 64'(done), 64'(m_done));
      check(hi === m_hi, {m_tag, " hi"}, 64'(hi), 64'(m_hi));
      check(lo === m_lo, {m_tag, " lo"}, 64'(lo), 64'(m_lo));
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R8 watchdog actual=%0d cycles expected=completion", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic dv, input logic sg, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    while (busy) @(negedge clk);
    cur_tag = tag;
    op_div = dv; is_signed = sg; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input logic dv, input logic sg, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
    issue(dv, sg, a, b, tag);
    repeat (36) @(negedge clk);
  endtask

  task automatic expect_result(input logic [63:0] exp, input string tag);
    check({hi, lo} === exp, tag, {hi, lo}, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 1'b0 && done === 1'b0, "R1 flags", {62'd0, busy, done}, 64'd0);
    check({hi, lo} === 64'd0, "R1 results", {hi, lo}, 64'd0);
    rst = 1'b0;
    running = 1;
    @(negedge clk);

    // R2 unsigned multiply
    run_op(0, 0, 32'd7, 32'd6, "R2");
    expect_result(64'd42, "R2 7*6");
    run_op(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    expect_result(64'hFFFF_FFFE_0000_0001, "R2 max*max");

    // R3 signed multiply
    run_op(0, 1, 32'd7, -32'sd6, "R3");
    expect_result(-64'sd42, "R3 7*-6");
    run_op(0, 1, 32'h8000_0000, 32'h8000_0000, "R3");
    expect_result(64'h4000_0000_0000_0000, "R3 min*min");
    run_op(0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    expect_result(64'd1, "R3 -1*-1");

    // R4 unsigned divide
    run_op(1, 0, 32'd100, 32'd7, "R4");
    expect_result({32'd2, 32'd14}, "R4 100/7");
    run_op(1, 0, 32'hFFFF_FFFF, 32'h8000_0000, "R4");
    expect_result({32'h7FFF_FFFF, 32'd1}, "R4 big");

    // R5 signed divide sign rules
    run_op(1, 1, -32'sd7, 32'd2, "R5");
    expect_result({-32'sd1, -32'sd3}, "R5 -7/2");
    run_op(1, 1, 32'd7, -32'sd2, "R5");
    expect_result({32'd1, -32'sd3}, "R5 7/-2");
    run_op(1, 1, -32'sd7, -32'sd2, "R5");
    expect_result({-32'sd1, 32'd3}, "R5 -7/-2");

    // R6 divide by zero
    run_op(1, 0, 32'd12345, 32'd0, "R6");
    expect_result({32'd12345, 32'hFFFF_FFFF}, "R6 unsigned /0");
    run_op(1, 1, -32'sd5, 32'd0, "R6");
    expect_result({-32'sd5, 32'd1}, "R6 signed neg /0");
    run_op(1, 1, 32'd5, 32'd0, "R6");
    expect_result({32'd5, 32'hFFFF_FFFF}, "R6 signed pos /0");

    // R7 quotient overflow
    run_op(1, 1, 32'h8000_0000, 32'hFFFF_FFFF, "R7");
    expect_result({32'd0, 32'h8000_0000}, "R7 min/-1");

    // R11 same operands, each encoding
    run_op(0, 0, 32'd20, 32'd4, "R11");
    expect_result(64'd80, "R11 mul select");
    run_op(1, 0, 32'd20, 32'd4, "R11");
    expect_result({32'd0, 32'd5}, "R11 div select");
    run_op(1, 1, 32'hFFFF_FFEC, 32'd4, "R11");
    expect_result({32'd0, -32'sd5}, "R11 signed select");

    // R9 start while busy is ignored
    issue(0, 0, 32'd3, 32'd5, "R9");
    repeat (5) @(negedge clk);
    cur_tag = "R9";
    op_div = 1; is_signed = 1; opa = 32'd99; opb = 32'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (32) @(negedge clk);
    expect_result(64'd15, "R9 first op kept");

    // R10 hold while idle
    repeat (10) @(negedge clk);
    expect_result(64'd15, "R10 hold");

    // R8 start in the done cycle is accepted
    issue(0, 0, 32'd11, 32'd11, "R8");
    while (!done) @(negedge clk);
    cur_tag = "R8";
    op_div = 0; is_signed = 0; opa = 32'd12; opb = 32'd12; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R8 back-to-back busy", 64'(busy), 64'd1);
    repeat (36) @(negedge clk);
    expect_result(64'd144, "R8 back-to-back result");

    // random mix: R2 R3 R4 R5
    for (int i = 0; i < 40; i++) begin
      logic dv, sg;
      logic [31:0] a, b;
      dv = 1'($urandom);
      sg = 1'($urandom);
      a = $urandom;
      b = (($urandom % 4) == 0) ? (($urandom % 16) + 1) : $urandom;
      run_op(dv, sg, a, b, dv ? (sg ? "R5" : "R4") : (sg ? "R3" : "R2"));
      expect_result(ref_result(dv, sg, a, b), "random op");
    end

    running = 0;
    summary();
    $finish;
  end

endmodule